// File: doc/BRIEF.md
# Condition and Overflow Flag Register

This block holds the processor's condition state for an integer pipeline. It has a 32-bit condition register split into eight 4-bit fields, and a 32-bit exception register that keeps carry, overflow and a sticky summary-overflow bit. Every cycle the integer datapath may present a result along with its carry-out and overflow. Separate strobes ask the block to record the carry, the overflow, or a sign/zero summary of the result in field 0. Compare results can be placed into any field. A move operation transfers the exception flags into a chosen field and clears them.

Software-visible state can be overwritten through whole-register write ports for both registers. A dedicated input clears the sticky bit. A registered field read port returns one selected field for branch evaluation. Fields are numbered big-endian: field 0 sits in the most significant nibble.

Top module: `cond_flag_reg`

## Requirements
- R1: After a synchronous reset, `cr_q`, `xer_q` and `rd_field` are all zero.
- R2: Field n occupies `cr_q[31-4n -: 4]`. A compare write (`cmp_wr`) stores the nibble {lt, gt, eq, summary-overflow} into the field named by `cmp_sel`, with lt in the nibble's MSB. All other fields are unchanged.
- R3: With `cr0_rec` set, field 0 becomes {negative, positive, zero, summary-overflow} for the signed value `alu_result`. Exactly one of its top three bits is set.
- R4: With `ovf_rec` set, the overflow flag `xer_q[30]` takes `alu_ovf`, whether that value is 0 or 1.
- R5: The summary-overflow flag `xer_q[31]` is set by `ovf_rec` together with `alu_ovf`. Once set, it stays set until `xer_wr`, `mvx_wr` or `so_clr` clears it.
- R6: With `carry_rec` set, the carry flag `xer_q[29]` takes `alu_carry`.
- R7: Bits 28:0 of `xer_q` always read zero. The `xer_wr` input loads the three flags from `xer_wdata[31:29]`.
- R8: `mvx_wr` writes {summary-overflow, overflow, carry, 0} into field `mvx_sel`, taking the flag values held before the edge. It then clears all three flags. This clear wins over any flag set in the same cycle, and `so_clr` wins in the same way.
- R9: `cr_wr` loads `cr_wdata` and `xer_wr` loads the flags. Each overrides every other update to its own register in the same cycle.
- R10: When several writes hit one field in the same cycle, the move wins over the compare, and the compare wins over the field 0 record.
- R11: `rd_field` shows field `rd_sel` of `cr_q` as it stood before the clock edge. The value is registered, with one cycle of latency.
- R12: When an overflow is recorded in the same cycle as a field 0 record or a compare, the stored summary-overflow bit is the value after that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | 32 | Signed integer result |
| alu_carry | input | 1 | Carry-out of the operation |
| alu_ovf | input | 1 | Signed overflow of the operation |
| carry_rec | input | 1 | Record carry flag |
| ovf_rec | input | 1 | Record overflow flag |
| cr0_rec | input | 1 | Record result summary in field 0 |
| cmp_wr | input | 1 | Compare result write |
| cmp_sel | input | 3 | Target field of the compare |
| cmp_lt | input | 1 | Compare less-than |
| cmp_gt | input | 1 | Compare greater-than |
| cmp_eq | input | 1 | Compare equal |
| mvx_wr | input | 1 | Move exception flags into a field and clear them |
| mvx_sel | input | 3 | Target field of the move |
| so_clr | input | 1 | Clear summary-overflow |
| cr_wr | input | 1 | Whole condition register write |
| cr_wdata | input | 32 | Condition register write data |
| xer_wr | input | 1 | Whole exception register write |
| xer_wdata | input | 32 | Exception register write data |
| rd_sel | input | 3 | Field read select |
| rd_field | output | 4 | Selected field, registered |
| cr_q | output | 32 | Condition register |
| xer_q | output | 32 | Exception register |

## Verification
The sharpest collision is an overflow update landing in the same cycle as a field 0 record or a compare. In that case the summary-overflow bit copied into the field must be the freshly updated value. A second collision is a move or clear arriving in the same cycle as an overflow set. Directed cycles raise each pair together, and random cycles raise the strobes independently so that further pairings also occur, including whole-register writes against flag updates. Each cycle is judged against a bench model that applies the stated priorities, with the mismatch tagged by the highest-priority operation that was active.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int unsigned FLD_W = 4;
  typedef logic [FLD_W-1:0] fld_t;

  // Pack a field MSB-first: less, greater, equal, summary
  function automatic fld_t pack_fld(input logic lt, input logic gt,
                                    input logic eq, input logic so);
    return {lt, gt, eq, so};
  endfunction
endpackage

// File: rtl/cfr_xer.sv
module cfr_xer #(
  parameter int unsigned XER_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [XER_W-1:0] wdata,
  input  logic             carry_rec,
  input  logic             carry,
  input  logic             ovf_rec,
  input  logic             ovf,
  input  logic             so_clr,
  input  logic             mv_clr,
  output logic             so_q,
  output logic             ov_q,
  output logic             ca_q,
  output logic             so_nxt,
  output logic [XER_W-1:0] xer_q
);
  localparam int unsigned PAD_W = XER_W - 3;

  logic so_d, ov_d, ca_d;

  always_comb begin
    so_d = so_q;
    ov_d = ov_q;
    ca_d = ca_q;
    if (wr) begin
      so_d = wdata[XER_W-1];
      ov_d = wdata[XER_W-2];
      ca_d = wdata[XER_W-3];
    end else begin
      if (carry_rec) ca_d = carry;
      if (ovf_rec) begin
        ov_d = ovf;
        if (ovf) so_d = 1'b1;
      end
      if (so_clr) so_d = 1'b0;
      if (mv_clr) begin
        so_d = 1'b0;
        ov_d = 1'b0;
        ca_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q <= 1'b0;
      ov_q <= 1'b0;
      ca_q <= 1'b0;
    end else begin
      so_q <= so_d;
      ov_q <= ov_d;
      ca_q <= ca_d;
    end
  end

  assign so_nxt = so_d;
  assign xer_q  = {so_q, ov_q, ca_q, {PAD_W{1'b0}}};

  // R5
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (so_q && !wr && !mv_clr && !so_clr) |=> so_q);

  // R4
  ov_track_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_rec && !wr && !mv_clr) |=> (ov_q == $past(ovf)));

  // R8
  mv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_clr && !wr) |=> (!so_q && !ov_q && !ca_q));
endmodule

// File: rtl/cfr_crf.sv
module cfr_crf
  import cfr_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned SEL_W      = $clog2(NUM_FIELDS),
  parameter int unsigned CR_W       = NUM_FIELDS * FLD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CR_W-1:0]  wdata,
  input  logic             rec_en,
  input  fld_t             rec_fld,
  input  logic             cmp_en,
  input  logic [SEL_W-1:0] cmp_sel,
  input  fld_t             cmp_fld,
  input  logic             mv_en,
  input  logic [SEL_W-1:0] mv_sel,
  input  fld_t             mv_fld,
  output logic [CR_W-1:0]  cr_q
);
  fld_t fld_q [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int unsigned HI = CR_W - 1 - g * FLD_W;
    fld_t nxt;
    logic rec_hit;

    if (g == 0) begin : g_rec
      assign rec_hit = rec_en;
    end else begin : g_norec
      assign rec_hit = 1'b0;
    end

    // Move beats compare, compare beats record
    always_comb begin
      nxt = fld_q[g];
      if (rec_hit) nxt = rec_fld;
      if (cmp_en && (cmp_sel == SEL_W'(g))) nxt = cmp_fld;
      if (mv_en && (mv_sel == SEL_W'(g))) nxt = mv_fld;
    end

    always_ff @(posedge clk) begin
      if (rst)     fld_q[g] <= '0;
      else if (wr) fld_q[g] <= wdata[HI -: FLD_W];
      else         fld_q[g] <= nxt;
    end

    assign cr_q[HI -: FLD_W] = fld_q[g];
  end

  // R9
  cr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cr_q == $past(wdata)));

  // R10
  mv_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_en && cmp_en && (mv_sel == cmp_sel) && !wr) |=>
      (fld_q[$past(mv_sel)] == $past(mv_fld)));
endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import cfr_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned XER_W      = 32,
  parameter int unsigned SEL_W      = $clog2(NUM_FIELDS),
  parameter int unsigned CR_W       = NUM_FIELDS * FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              carry_rec,
  input  logic              ovf_rec,
  input  logic              cr0_rec,
  input  logic              cmp_wr,
  input  logic [SEL_W-1:0]  cmp_sel,
  input  logic              cmp_lt,
  input  logic              cmp_gt,
  input  logic              cmp_eq,
  input  logic              mvx_wr,
  input  logic [SEL_W-1:0]  mvx_sel,
  input  logic              so_clr,
  input  logic              cr_wr,
  input  logic [CR_W-1:0]   cr_wdata,
  input  logic              xer_wr,
  input  logic [XER_W-1:0]  xer_wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [FLD_W-1:0]  rd_field,
  output logic [CR_W-1:0]   cr_q,
  output logic [XER_W-1:0]  xer_q
);
  logic so_q, ov_q, ca_q, so_nxt;
  logic res_neg, res_zero, res_pos;
  fld_t rec_fld, cmp_fld, mv_fld;

  cfr_xer #(.XER_W(XER_W)) u_xer (
    .clk(clk), .rst(rst), .wr(xer_wr), .wdata(xer_wdata),
    .carry_rec(carry_rec), .carry(alu_carry),
    .ovf_rec(ovf_rec), .ovf(alu_ovf),
    .so_clr(so_clr), .mv_clr(mvx_wr),
    .so_q(so_q), .ov_q(ov_q), .ca_q(ca_q), .so_nxt(so_nxt), .xer_q(xer_q)
  );

  assign res_neg  = alu_result[DATA_W-1];
  assign res_zero = ~|alu_result;
  assign res_pos  = ~res_neg & ~res_zero;
  assign rec_fld  = pack_fld(res_neg, res_pos, res_zero, so_nxt);
  assign cmp_fld  = pack_fld(cmp_lt, cmp_gt, cmp_eq, so_nxt);
  assign mv_fld   = pack_fld(so_q, ov_q, ca_q, 1'b0);

  cfr_crf #(.NUM_FIELDS(NUM_FIELDS)) u_crf (
    .clk(clk), .rst(rst), .wr(cr_wr), .wdata(cr_wdata),
    .rec_en(cr0_rec), .rec_fld(rec_fld),
    .cmp_en(cmp_wr), .cmp_sel(cmp_sel), .cmp_fld(cmp_fld),
    .mv_en(mvx_wr), .mv_sel(mvx_sel), .mv_fld(mv_fld),
    .cr_q(cr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_field <= '0;
    else     rd_field <= cr_q[(CR_W-1) - FLD_W*rd_sel -: FLD_W];
  end

  logic f0_busy;
  assign f0_busy = cr_wr || (cmp_wr && cmp_sel == '0) || (mvx_wr && mvx_sel == '0);

  // R3
  rec_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (cr0_rec && !f0_busy) |=>
      ((cr_q[CR_W-1] == $past(alu_result[DATA_W-1])) &&
       ($countones(cr_q[CR_W-1 -: 3]) == 1)));

  // R12
  rec_so_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    (cr0_rec && !f0_busy && ovf_rec && alu_ovf && !xer_wr && !mvx_wr && !so_clr)
      |=> cr_q[CR_W-FLD_W]);

  // R11
  rd_port_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (rd_field == $past(cr_q[(CR_W-1) - FLD_W*rd_sel -: FLD_W])));
endmodule

// File: tb/cond_flag_reg_tb.sv
module cond_flag_reg_tb;
  logic clk = 1'b0;
  logic rst;
  logic [31:0] alu_result;
  logic alu_carry, alu_ovf, carry_rec, ovf_rec, cr0_rec;
  logic cmp_wr, cmp_lt, cmp_gt, cmp_eq, mvx_wr, so_clr, cr_wr, xer_wr;
  logic [2:0] cmp_sel, mvx_sel, rd_sel;
  logic [31:0] cr_wdata, xer_wdata;
  logic [3:0] rd_field;
  logic [31:0] cr_q, xer_q;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_cr;
  logic m_so, m_ov, m_ca;

  always #10 clk = ~clk;

  cond_flag_reg u_dut (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .carry_rec(carry_rec), .ovf_rec(ovf_rec),
    .cr0_rec(cr0_rec), .cmp_wr(cmp_wr), .cmp_sel(cmp_sel), .cmp_lt(cmp_lt),
    .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .mvx_wr(mvx_wr), .mvx_sel(mvx_sel),
    .so_clr(so_clr), .cr_wr(cr_wr), .cr_wdata(cr_wdata), .xer_wr(xer_wr),
    .xer_wdata(xer_wdata), .rd_sel(rd_sel), .rd_field(rd_field),
    .cr_q(cr_q), .xer_q(xer_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] fld_of(input logic [31:0] r, input int n);
    return r[31-4*n -: 4];
  endfunction

  function automatic logic [31:0] set_fld(input logic [31:0] r, input int n, input logic [3:0] f);
    logic [31:0] t = r;
    t[31-4*n -: 4] = f;
    return t;
  endfunction

  task automatic idle_in();
    alu_result = '0; alu_carry = 0; alu_ovf = 0; carry_rec = 0; ovf_rec = 0;
    cr0_rec = 0; cmp_wr = 0; cmp_lt = 0; cmp_gt = 0; cmp_eq = 0; mvx_wr = 0;
    so_clr = 0; cr_wr = 0; xer_wr = 0; cmp_sel = '0; mvx_sel = '0; rd_sel = '0;
    cr_wdata = '0; xer_wdata = '0;
  endtask

  // Inputs are set by the caller at a falling edge; one rising edge follows.
  task automatic step();
    logic so_n, ov_n, ca_n;
    logic [31:0] cr_n;
    logic [3:0] rd_exp;
    logic neg, zer;
    string ctag, xtag;
    so_n = m_so; ov_n = m_ov; ca_n = m_ca;
    if (xer_wr) begin
      so_n = xer_wdata[31]; ov_n = xer_wdata[30]; ca_n = xer_wdata[29];
    end else begin
      if (carry_rec) ca_n = alu_carry;
      if (ovf_rec) begin ov_n = alu_ovf; if (alu_ovf) so_n = 1'b1; end
      if (so_clr) so_n = 1'b0;
      if (mvx_wr) begin so_n = 0; ov_n = 0; ca_n = 0; end
    end
    neg = alu_result[31];
    zer = (alu_result == 0);
    cr_n = m_cr;
    if (cr_wr) cr_n = cr_wdata;
    else begin
      if (cr0_rec) cr_n = set_fld(cr_n, 0, {neg, !neg && !zer, zer, so_n});
      if (cmp_wr) cr_n = set_fld(cr_n, int'(cmp_sel), {cmp_lt, cmp_gt, cmp_eq, so_n});
      if (mvx_wr) cr_n = set_fld(cr_n, int'(mvx_sel), {m_so, m_ov, m_ca, 1'b0});
    end
    rd_exp = fld_of(m_cr, int'(rd_sel));
    if (cr_wr) ctag = "R9";
    else if (mvx_wr && cmp_wr && mvx_sel == cmp_sel) ctag = "R10";
    else if (mvx_wr) ctag = "R8";
    else if ((cr0_rec || cmp_wr) && ovf_rec && alu_ovf) ctag = "R12";
    else if (cr0_rec) ctag = "R3";
    else ctag = "R2";
    if (xer_wr) xtag = "R9";
    else if (mvx_wr || so_clr) xtag = "R8";
    else if (ovf_rec) xtag = "R4";
    else if (carry_rec) xtag = "R6";
    else xtag = "R5";
    @(posedge clk);
    @(negedge clk);
    m_cr = cr_n; m_so = so_n; m_ov = ov_n; m_ca = ca_n;
    chk(ctag, cr_q, m_cr);
    chk(xtag, {29'b0, xer_q[31:29]}, {29'b0, m_so, m_ov, m_ca});
    chk("R7", {3'b0, xer_q[28:0]}, 32'h0);
    chk("R11", {28'b0, rd_field}, {28'b0, rd_exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle_in();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", cr_q, 32'h0);
    chk("R1", xer_q, 32'h0);
    chk("R1", {28'b0, rd_field}, 32'h0);
    m_cr = '0; m_so = 0; m_ov = 0; m_ca = 0;

    // R2 compare into field 5, placement at bits 11:8
    idle_in(); cmp_wr = 1; cmp_sel = 3'd5; cmp_lt = 1; step();
    chk("R2", {28'b0, cr_q[11:8]}, 32'h8);
    // R12 overflow and field 0 record together, negative result
    idle_in(); ovf_rec = 1; alu_ovf = 1; cr0_rec = 1; alu_result = 32'h8000_0001; step();
    chk("R12", {28'b0, cr_q[31:28]}, 32'h9);
    // R4 / R5 overflow cleared, summary stays; zero result
    idle_in(); ovf_rec = 1; alu_ovf = 0; cr0_rec = 1; rd_sel = 3'd5; step();
    chk("R5", {31'b0, xer_q[31]}, 32'h1);
    chk("R4", {31'b0, xer_q[30]}, 32'h0);
    chk("R3", {28'b0, cr_q[31:28]}, 32'h3);
    // R6 carry
    idle_in(); carry_rec = 1; alu_carry = 1; rd_sel = 3'd0; step();
    chk("R6", {31'b0, xer_q[29]}, 32'h1);
    // R10 move and compare on field 2, with an overflow set the same cycle
    idle_in(); mvx_wr = 1; mvx_sel = 3'd2; cmp_wr = 1; cmp_sel = 3'd2; cmp_gt = 1;
    ovf_rec = 1; alu_ovf = 1; step();
    chk("R10", {28'b0, cr_q[23:20]}, 32'hA);
    chk("R8", xer_q, 32'h0);
    // R9 whole writes beat updates
    idle_in(); cr_wr = 1; cr_wdata = 32'h1234_5678; cmp_wr = 1; cmp_sel = 3'd7;
    xer_wr = 1; xer_wdata = 32'h4000_0000; ovf_rec = 1; alu_ovf = 1; step();
    chk("R9", cr_q, 32'h1234_5678);
    chk("R9", xer_q, 32'h4000_0000);
    // R8 so_clr against same-cycle overflow
    idle_in(); ovf_rec = 1; alu_ovf = 1; so_clr = 1; step();
    chk("R8", {31'b0, xer_q[31]}, 32'h0);
    // R3 positive result
    idle_in(); cr0_rec = 1; alu_result = 32'h0000_0042; step();
    chk("R3", {28'b0, cr_q[31:28]}, 32'h4);

    for (int i = 0; i < 4000; i++) begin
      idle_in();
      case ($urandom_range(0, 3))
        0: alu_result = '0;
        1: alu_result = 32'h8000_0000 | $urandom;
        default: alu_result = $urandom;
      endcase
      alu_carry = $urandom_range(0, 1) == 1;
      alu_ovf   = $urandom_range(0, 3) == 0;
      carry_rec = $urandom_range(0, 1) == 1;
      ovf_rec   = $urandom_range(0, 1) == 1;
      cr0_rec   = $urandom_range(0, 1) == 1;
      cmp_wr    = $urandom_range(0, 2) == 0;
      cmp_sel   = 3'($urandom_range(0, 7));
      {cmp_lt, cmp_gt, cmp_eq} = 3'b001 << $urandom_range(0, 2);
      mvx_wr    = $urandom_range(0, 11) == 0;
      mvx_sel   = 3'($urandom_range(0, 7));
      so_clr    = $urandom_range(0, 19) == 0;
      cr_wr     = $urandom_range(0, 29) == 0;
      cr_wdata  = $urandom;
      xer_wr    = $urandom_range(0, 29) == 0;
      xer_wdata = $urandom;
      rd_sel    = 3'($urandom_range(0, 7));
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule